// File: doc/BRIEF.md
# Fast Link Training Sequencer

This block runs the short, handshake-free variant of display link training. When the sink says it can train this way and the earlier full training left both its clock-lock and equalization flags set, the block runs a fixed sequence of register accesses over a sideband port. It writes the link setup, sends the clock-recovery pattern for a timed period, then sends the equalization pattern for a second timed period. It reads the lane status once and always ends by turning the training pattern off.

The two timed periods are counted in pulses of an external one-microsecond tick, up to a parameterized count (500 by default). A sideband error, a lane that has not locked its clock, or a lane that has not equalized all count as a failure. When the attempt fails, or cannot be made at all, the block raises a fallback request so that the full training sequencer runs next. A pass ends the job and no full training follows.

Top module: `fast_train_seq`

## Requirements
- R1: A start when the sink does not support fast training, or when either stored flag (clock-ok, equalized-ok) is low, makes no sideband access and finishes with fallback=1 and pass=0.
- R2: An eligible start first issues a sideband write of `cfgData` to address ADDR_CFG (default 0x00100).
- R3: The second access writes pattern byte 0x21 (pattern 1) to ADDR_PAT (default 0x00102). The next access is not issued until HOLD_US tick pulses have arrived after that write was acknowledged.
- R4: The third access writes 0x23 (pattern 3) to ADDR_PAT when `sinkTps3Cap` is high, and 0x22 (pattern 2) otherwise. It is also held for HOLD_US ticks after its acknowledge.
- R5: A pattern byte holds the pattern number in bits [1:0]. Bit 5 (scrambler off) is set whenever that number is non-zero. The disable byte is 0x00.
- R6: After the second hold there is exactly one sideband read of ADDR_STAT (default 0x00202). Status bits [LANES-1:0] are clock-lock per lane and bits [2*LANES-1:LANES] are equalized per lane. Any zero among them means fail.
- R7: The last access of every eligible run is a write of 0x00 to ADDR_PAT, whether the run passes or fails.
- R8: An acknowledge with `sbErr` high marks the run as failed (fallback=1). The only access that may follow it is the disable write. An error on the disable write itself ends the run.
- R9: `done` pulses for one cycle. It comes 2 cycles after the start edge on an ineligible run, and 2 cycles after the disable write's acknowledge edge on an eligible one. `pass` and `fallback` are exact opposites from that pulse until the next start.
- R10: `sbReq` stays high with stable `sbWrite`, `sbAddr` and `sbWdata` until `sbAck`. It drops in the acknowledge cycle and stays low for at least one cycle before the next access.
- R11: `busy` is high from the cycle after an accepted start until the `done` pulse. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an attempt (pulse) |
| sinkFastCap | input | 1 | Sink supports fast training |
| sinkTps3Cap | input | 1 | Sink supports pattern 3 |
| prevClockOk | input | 1 | Stored clock-lock flag from earlier training |
| prevEqualOk | input | 1 | Stored equalized flag from earlier training |
| cfgData | input | DW | Link setup byte written first |
| usTick | input | 1 | One-cycle pulse every microsecond |
| sbReq | output | 1 | Sideband access request |
| sbWrite | output | 1 | 1 = write, 0 = read |
| sbAddr | output | AW | Sideband address |
| sbWdata | output | DW | Sideband write data |
| sbAck | input | 1 | Sideband access complete |
| sbErr | input | 1 | Access failed (valid with sbAck) |
| sbRdata | input | DW | Read data (valid with sbAck) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Fast training succeeded |
| fallback | output | 1 | Full training is required |

## Verification
The next sideband request is due 2 cycles after each acknowledge edge. The done pulse is due 2 cycles after the disable write's acknowledge edge, or 2 cycles after the start edge when the sink or the stored flags rule fast training out. The bench model records the cycle number and the tick count at each acknowledge and checks these fixed offsets against them. After a pattern write, the next request must come after exactly HOLD_US more ticks, with a margin of one tick for the two-cycle issue delay. Every clock the request is checked for stability and for the one-cycle gap that follows an acknowledge.

// File: rtl/fast_train_pkg.sv
package fast_train_pkg;

  typedef enum logic [2:0] {
    OP_CFG,
    OP_PAT1,
    OP_PAT2,
    OP_READ,
    OP_OFF
  } sbOp_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_HOLD,
    ST_FIN
  } ftState_e;

  typedef struct packed {
    logic  issue;
    sbOp_e op;
    logic  timerClr;
    logic  clearRes;
    logic  markFail;
    logic  finish;
  } ftStrobe_t;

  localparam int SCRAMBLE_OFF_BIT = 5;

endpackage

// File: rtl/fast_train_ctrl.sv
module fast_train_ctrl
  import fast_train_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      sinkFastCap,
  input  logic      prevClockOk,
  input  logic      prevEqualOk,
  input  logic      sbAck,
  input  logic      sbErr,
  input  logic      tmrExpire,
  output ftStrobe_t strb,
  output logic      busy
);

  ftState_e st, stNext;
  sbOp_e    opR, opNext;
  logic     eligible;

  assign eligible = sinkFastCap & prevClockOk & prevEqualOk;
  assign busy     = (st != ST_IDLE);

  always_comb begin
    stNext = st;
    opNext = opR;
    strb   = '0;
    case (st)
      ST_IDLE: begin
        if (start) begin
          strb.clearRes = 1'b1;
          if (eligible) begin
            opNext = OP_CFG;
            stNext = ST_SEND;
          end else begin
            strb.markFail = 1'b1;
            stNext        = ST_FIN;
          end
        end
      end
      ST_SEND: begin
        strb.issue = 1'b1;
        strb.op    = opR;
        stNext     = ST_WAIT;
      end
      ST_WAIT: begin
        if (sbAck) begin
          if (opR == OP_OFF) begin
            stNext = ST_FIN;
          end else if (sbErr) begin
            opNext = OP_OFF;
            stNext = ST_SEND;
          end else begin
            case (opR)
              OP_CFG: begin
                opNext = OP_PAT1;
                stNext = ST_SEND;
              end
              OP_PAT1, OP_PAT2: begin
                strb.timerClr = 1'b1;
                stNext        = ST_HOLD;
              end
              default: begin
                opNext = OP_OFF;
                stNext = ST_SEND;
              end
            endcase
          end
        end
      end
      ST_HOLD: begin
        if (tmrExpire) begin
          opNext = (opR == OP_PAT1) ? OP_PAT2 : OP_READ;
          stNext = ST_SEND;
        end
      end
      default: begin
        strb.finish = 1'b1;
        stNext      = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st  <= ST_IDLE;
      opR <= OP_CFG;
    end else begin
      st  <= stNext;
      opR <= opNext;
    end
  end

  AST_SKIP_FAST: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_IDLE && start && !eligible) |=> (st == ST_FIN)); // R1

  AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_HOLD && !tmrExpire) |=> (st == ST_HOLD)); // R3

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_HOLD && start && !tmrExpire) |=> (st == ST_HOLD && $stable(opR))); // R11

endmodule

// File: rtl/fast_train_datapath.sv
module fast_train_datapath
  import fast_train_pkg::*;
#(
  parameter int             LANES     = 4,
  parameter int             DW        = 8,
  parameter int             AW        = 20,
  parameter int             HOLD_US   = 500,
  parameter logic [AW-1:0]  ADDR_CFG  = 20'h00100,
  parameter logic [AW-1:0]  ADDR_PAT  = 20'h00102,
  parameter logic [AW-1:0]  ADDR_STAT = 20'h00202
) (
  input  logic          clk,
  input  logic          rstN,
  input  ftStrobe_t     strb,
  input  logic          sinkTps3Cap,
  input  logic [DW-1:0] cfgData,
  input  logic          usTick,
  input  logic          sbAck,
  input  logic          sbErr,
  input  logic [DW-1:0] sbRdata,
  output logic          sbReq,
  output logic          sbWrite,
  output logic [AW-1:0] sbAddr,
  output logic [DW-1:0] sbWdata,
  output logic          tmrExpire,
  output logic          done,
  output logic          pass,
  output logic          fallback
);

  localparam int CW = $clog2(HOLD_US + 1);
  localparam logic [CW-1:0] LAST_TICK = CW'(HOLD_US - 1);

  logic [CW-1:0]    tickCnt;
  sbOp_e            curOp;
  logic             failR;
  logic [LANES-1:0] laneLock, laneEq;
  logic             statusBad, ackNow;

  function automatic logic [DW-1:0] patByte(input logic [1:0] code);
    logic [DW-1:0] b;
    b = '0;
    if (code != 2'd0) begin
      b[1:0]             = code;
      b[SCRAMBLE_OFF_BIT] = 1'b1;
    end
    return b;
  endfunction

  assign laneLock  = sbRdata[LANES-1:0];
  assign laneEq    = sbRdata[2*LANES-1:LANES];
  assign statusBad = ~(&laneLock) | ~(&laneEq);
  assign ackNow    = sbReq & sbAck;
  assign tmrExpire = usTick & (tickCnt == LAST_TICK);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sbReq    <= 1'b0;
      sbWrite  <= 1'b0;
      sbAddr   <= '0;
      sbWdata  <= '0;
      curOp    <= OP_CFG;
      tickCnt  <= '0;
      failR    <= 1'b0;
      done     <= 1'b0;
      pass     <= 1'b0;
      fallback <= 1'b0;
    end else begin
      if (strb.issue) begin
        sbReq <= 1'b1;
        curOp <= strb.op;
        case (strb.op)
          OP_CFG: begin
            sbWrite <= 1'b1;
            sbAddr  <= ADDR_CFG;
            sbWdata <= cfgData;
          end
          OP_PAT1: begin
            sbWrite <= 1'b1;
            sbAddr  <= ADDR_PAT;
            sbWdata <= patByte(2'd1);
          end
          OP_PAT2: begin
            sbWrite <= 1'b1;
            sbAddr  <= ADDR_PAT;
            sbWdata <= patByte(sinkTps3Cap ? 2'd3 : 2'd2);
          end
          OP_READ: begin
            sbWrite <= 1'b0;
            sbAddr  <= ADDR_STAT;
            sbWdata <= '0;
          end
          default: begin
            sbWrite <= 1'b1;
            sbAddr  <= ADDR_PAT;
            sbWdata <= patByte(2'd0);
          end
        endcase
      end else if (ackNow) begin
        sbReq <= 1'b0;
      end

      if (strb.timerClr)
        tickCnt <= '0;
      else if (usTick && tickCnt != LAST_TICK)
        tickCnt <= tickCnt + 1'b1;

      if (strb.clearRes)
        failR <= strb.markFail;
      else if (strb.markFail)
        failR <= 1'b1;
      else if (ackNow && (sbErr || (curOp == OP_READ && statusBad)))
        failR <= 1'b1;

      done <= strb.finish;
      if (strb.clearRes) begin
        pass     <= 1'b0;
        fallback <= 1'b0;
      end else if (strb.finish) begin
        pass     <= ~failR;
        fallback <= failR;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (sbReq && !sbAck) |=> (sbReq && $stable(sbAddr) && $stable(sbWdata) && $stable(sbWrite))); // R10

  AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (sbReq && sbAck) |=> !sbReq); // R10

  AST_SCRAMBLE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (sbReq && sbWrite && sbAddr == ADDR_PAT && sbWdata[1:0] != 2'd0) |-> sbWdata[SCRAMBLE_OFF_BIT]); // R5

  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (pass != fallback)); // R9

endmodule

// File: rtl/fast_train_seq.sv
module fast_train_seq
  import fast_train_pkg::*;
#(
  parameter int             LANES     = 4,
  parameter int             DW        = 8,
  parameter int             AW        = 20,
  parameter int             HOLD_US   = 500,
  parameter logic [AW-1:0]  ADDR_CFG  = 20'h00100,
  parameter logic [AW-1:0]  ADDR_PAT  = 20'h00102,
  parameter logic [AW-1:0]  ADDR_STAT = 20'h00202
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          sinkFastCap,
  input  logic          sinkTps3Cap,
  input  logic          prevClockOk,
  input  logic          prevEqualOk,
  input  logic [DW-1:0] cfgData,
  input  logic          usTick,
  output logic          sbReq,
  output logic          sbWrite,
  output logic [AW-1:0] sbAddr,
  output logic [DW-1:0] sbWdata,
  input  logic          sbAck,
  input  logic          sbErr,
  input  logic [DW-1:0] sbRdata,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fallback
);

  ftStrobe_t strb;
  logic      tmrExpire;

  fast_train_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .sinkFastCap (sinkFastCap),
    .prevClockOk (prevClockOk),
    .prevEqualOk (prevEqualOk),
    .sbAck       (sbAck),
    .sbErr       (sbErr),
    .tmrExpire   (tmrExpire),
    .strb        (strb),
    .busy        (busy)
  );

  fast_train_datapath #(
    .LANES     (LANES),
    .DW        (DW),
    .AW        (AW),
    .HOLD_US   (HOLD_US),
    .ADDR_CFG  (ADDR_CFG),
    .ADDR_PAT  (ADDR_PAT),
    .ADDR_STAT (ADDR_STAT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .sinkTps3Cap (sinkTps3Cap),
    .cfgData     (cfgData),
    .usTick      (usTick),
    .sbAck       (sbAck),
    .sbErr       (sbErr),
    .sbRdata     (sbRdata),
    .sbReq       (sbReq),
    .sbWrite     (sbWrite),
    .sbAddr      (sbAddr),
    .sbWdata     (sbWdata),
    .tmrExpire   (tmrExpire),
    .done        (done),
    .pass        (pass),
    .fallback    (fallback)
  );

endmodule

// File: tb/fast_train_seq_test.sv
`timescale 1ns/1ps
module fast_train_seq_test;

  localparam int HOLD = 8;
  localparam logic [19:0] A_CFG  = 20'h00100;
  localparam logic [19:0] A_PAT  = 20'h00102;
  localparam logic [19:0] A_STAT = 20'h00202;

  logic clk = 0, rstN = 0, start = 0;
  logic sinkFastCap = 0, sinkTps3Cap = 0, prevClockOk = 0, prevEqualOk = 0;
  logic [7:0] cfgData = 0;
  logic usTick = 0;
  logic sbReq, sbWrite, sbAck = 0, sbErr = 0;
  logic [19:0] sbAddr;
  logic [7:0] sbWdata, sbRdata = 0;
  logic busy, done, pass, fallback;

  int errs = 0, checks = 0, cyc = 0;
  int tickDiv = 0, tickCount = 0, ackTicks = 0;
  bit holdArmed = 0, holdArmNext = 0, pending = 0;
  int lat = 0, opIdx = 0, errAt = -1, doneSeen = 0, expDoneCyc = -1;
  bit expPass = 0;
  logic [7:0] statusVal = 0;
  bit curWr; logic [19:0] curAddr; logic [7:0] curData;
  bit expWr[$]; logic [19:0] expAddr[$]; logic [7:0] expData[$]; string expTag[$];

  always #2.5 clk = ~clk;

  fast_train_seq #(.HOLD_US(HOLD)) uut (
    .clk(clk), .rstN(rstN), .start(start), .sinkFastCap(sinkFastCap),
    .sinkTps3Cap(sinkTps3Cap), .prevClockOk(prevClockOk), .prevEqualOk(prevEqualOk),
    .cfgData(cfgData), .usTick(usTick), .sbReq(sbReq), .sbWrite(sbWrite),
    .sbAddr(sbAddr), .sbWdata(sbWdata), .sbAck(sbAck), .sbErr(sbErr),
    .sbRdata(sbRdata), .busy(busy), .done(done), .pass(pass), .fallback(fallback));

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic pushOp(input bit wr, input logic [19:0] a, input logic [7:0] d,
                        input string tag);
    expWr.push_back(wr); expAddr.push_back(a); expData.push_back(d); expTag.push_back(tag);
  endtask

  // behavioural model of ticks, sideband target and result timing
  always @(negedge clk) begin
    cyc++;
    if (usTick) tickCount++;
    tickDiv = (tickDiv == 2) ? 0 : tickDiv + 1;
    usTick = (tickDiv == 0);

    if (done) begin
      doneSeen++;
      chk(cyc == expDoneCyc, "R9", "done cycle", cyc, expDoneCyc);
      chk(pass == expPass, expPass ? "R6" : "R8", "pass", pass, expPass);
      chk(fallback == !expPass, "R1 R8", "fallback", fallback, !expPass);
    end

    if (sbAck) begin
      sbAck = 0; sbErr = 0; sbRdata = 0; pending = 0;
      chk(sbReq == 0, "R10", "req low after ack", sbReq, 0);
      if (holdArmNext) begin ackTicks = tickCount; holdArmed = 1; holdArmNext = 0; end
    end else if (pending) begin
      chk(sbReq && sbWrite == curWr && sbAddr == curAddr && sbWdata == curData,
          "R10", "request stable", {sbReq, sbAddr, sbWdata}, {1'b1, curAddr, curData});
      if (lat == 0) begin
        sbAck = 1;
        sbErr = (opIdx == errAt);
        sbRdata = curWr ? 8'h00 : statusVal;
        if (curWr && curAddr == A_PAT && curData != 0 && !sbErr) holdArmNext = 1;
        if (curWr && curAddr == A_PAT && curData == 0) expDoneCyc = cyc + 2;
        opIdx++;
      end else lat--;
    end else if (sbReq) begin
      curWr = sbWrite; curAddr = sbAddr; curData = sbWdata;
      pending = 1; lat = 2;
      if (holdArmed) begin
        chk((tickCount - ackTicks) >= HOLD && (tickCount - ackTicks) <= HOLD + 1,
            "R3 R4", "ticks held", tickCount - ackTicks, HOLD);
        holdArmed = 0;
      end
      if (expWr.size() == 0) begin
        chk(0, "R1 R7", "unexpected access", sbAddr, 0);
      end else begin
        string t;
        t = expTag.pop_front();
        chk(sbWrite == expWr.pop_front(), t, "write flag", sbWrite, curWr);
        chk(sbAddr == expAddr.pop_front(), t, "address", sbAddr, curAddr);
        if (curWr) chk(sbWdata == expData.pop_front(), t, "data", sbWdata, curData);
        else void'(expData.pop_front());
      end
    end
  end

  task automatic runCase(input bit fast, input bit cr, input bit eq, input bit tps3,
                         input int errOp, input logic [7:0] status,
                         input logic [7:0] cfg, input bit extraStart);
    bit elig;
    elig = fast && cr && eq;
    expWr.delete(); expAddr.delete(); expData.delete(); expTag.delete();
    opIdx = 0; holdArmed = 0; holdArmNext = 0; doneSeen = 0; expDoneCyc = -1;
    errAt = errOp; statusVal = status;
    expPass = elig && errOp < 0 && status == 8'hFF;
    if (elig) begin
      pushOp(1, A_CFG, cfg, "R2");
      if (errOp != 0) pushOp(1, A_PAT, 8'h21, "R3 R5");
      if (errOp != 0 && errOp != 1)
        pushOp(1, A_PAT, tps3 ? 8'h23 : 8'h22, "R4 R5");
      if (errOp < 0 || errOp >= 3) pushOp(0, A_STAT, 8'h00, "R6");
      pushOp(1, A_PAT, 8'h00, errOp >= 0 ? "R7 R8" : "R7");
    end
    @(negedge clk); #1;
    sinkFastCap = fast; prevClockOk = cr; prevEqualOk = eq; sinkTps3Cap = tps3;
    cfgData = cfg; start = 1;
    if (!elig) expDoneCyc = cyc + 2;
    @(negedge clk); #1;
    start = 0;
    chk(busy == 1, "R11", "busy after start", busy, 1);
    if (extraStart) begin
      repeat (12) @(negedge clk);
      #1 start = 1;
      @(negedge clk); #1 start = 0;
    end
    for (int i = 0; i < 3000 && doneSeen == 0; i++) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(doneSeen == 1, "R9 R11", "done pulses", doneSeen, 1);
    chk(expWr.size() == 0, "R7", "missing accesses", expWr.size(), 0);
    chk(busy == 0, "R11", "idle after done", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 rstN = 1;
    @(negedge clk);
    chk(sbReq == 0 && done == 0 && busy == 0 && pass == 0 && fallback == 0,
        "R9 R10", "reset state", {sbReq, done, busy, pass, fallback}, 0);
    runCase(0, 1, 1, 0, -1, 8'hFF, 8'h0A, 0); // R1 no fast capability
    runCase(1, 0, 1, 0, -1, 8'hFF, 8'h0A, 0); // R1 clock flag clear
    runCase(1, 1, 0, 1, -1, 8'hFF, 8'h0A, 0); // R1 equalized flag clear
    runCase(1, 1, 1, 0, -1, 8'hFF, 8'h14, 0); // R2 R4 pattern 2 pass
    runCase(1, 1, 1, 1, -1, 8'hFF, 8'h84, 0); // R4 pattern 3 pass
    runCase(1, 1, 1, 0, -1, 8'hF7, 8'h0A, 0); // R6 lane 3 clock not locked
    runCase(1, 1, 1, 1, -1, 8'h7F, 8'h0A, 0); // R6 lane 3 not equalized
    runCase(1, 1, 1, 0, 0, 8'hFF, 8'h0A, 0);  // R8 error on setup write
    runCase(1, 1, 1, 1, 2, 8'hFF, 8'h0A, 0);  // R8 error on pattern 2 write
    runCase(1, 1, 1, 0, 3, 8'hFF, 8'h0A, 0);  // R8 error on status read
    runCase(1, 1, 1, 0, 4, 8'hFF, 8'h0A, 0);  // R8 error on disable write
    runCase(1, 1, 1, 1, -1, 8'hFF, 8'h33, 1); // R11 start during hold ignored
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule